// File: doc/BRIEF.md
# Two-Sided Mailbox Doorbell

This block joins two processor sides through a set of one-word mailbox channels. By default there are four channels of 32 bits each. The sending side (side B) writes a word into the transmit slot of a channel. That word is latched into the channel's holding register, and the channel's "full" flag is raised. The receiving side (side A) sees the flags in a read-only status word. It can enable an interrupt per channel in a control word, and it takes the word by reading the channel's receive slot. That read also clears the flag.

Because a plain bus write can act as an interrupt, side B's transmit slots can serve as the target address of a message-signalled interrupt. The write data carries the payload and the slot picks the channel. A single registered interrupt line tells side A that at least one enabled channel is full.

A parameter picks one of three address maps. Two of them are legacy layouts, where the per-channel bits sit reversed in the top byte. The third is a newer layout, where the per-channel bits sit at the bottom of the word. Each side has a simple register port with address, write strobe, write data, read strobe and read data. Read data is registered, so it appears one clock after the read strobe.

Top module: `mbox_doorbell`

## Requirements
- R1: A side-B write to the transmit slot of channel x (base TX + 4*x) stores the write data in channel x and raises channel x's full flag at the next clock edge.
- R2: The status word holds channel x's full flag at bit x in the newer map (MAP_WIDE). In the legacy maps it holds the flag at bit 24 + (3 - x), with NCH = 4. All other status bits read zero.
- R3: A side-A read of channel x's receive slot (base RX + 4*x) returns the stored word and clears only channel x's flag. The stored word itself is kept.
- R4: The control word is a full 32-bit read/write register. Channel x's interrupt enable is the control bit at the same position as its status flag (R2).
- R5: The interrupt output is a register that takes the OR over all channels of (flag AND enable). It rises or falls one clock after that condition changes.
- R6: Clearing a channel's enable drops the interrupt but leaves the flag set. Setting the enable again brings the interrupt back.
- R7: A side-B write to a channel that is already full replaces the stored word, and the flag stays set.
- R8: When a side-B write and a side-A receive read hit the same channel in the same cycle, the read returns the old word, the new word is stored and the flag stays set.
- R9: Reset clears every stored word, every flag, the control word, both read data outputs and the interrupt.
- R10: Writes to the status word, to receive slots or to unmapped addresses on either side change nothing. Reads of unmapped addresses return zero.
- R11: Read data shows the addressed register in the cycle after the read strobe and is zero after a cycle without a read. A side-B read of transmit slot x returns channel x's stored word.
- R12: Address maps. MAP_LEGACY_LO uses TX 0x000, RX 0x010, status 0x020 and control 0x024. MAP_LEGACY_HI uses TX 0x020, RX 0x040, status 0x060 and control 0x064. MAP_WIDE uses TX 0x200, RX 0x280, status 0x12C and control 0x128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| b_addr | input | ADDR_W | Side-B byte address |
| b_wr | input | 1 | Side-B write strobe |
| b_wdata | input | DATA_W | Side-B write data |
| b_rd | input | 1 | Side-B read strobe |
| b_rdata | output | DATA_W | Side-B registered read data |
| a_addr | input | ADDR_W | Side-A byte address |
| a_wr | input | 1 | Side-A write strobe |
| a_wdata | input | DATA_W | Side-A write data |
| a_rd | input | 1 | Side-A read strobe |
| a_rdata | output | DATA_W | Side-A registered read data |
| irq | output | 1 | Combined receive interrupt to side A |

## Verification
The assertions assume that the address ports are fully known while a strobe is high. They also assume that a side never raises its read and write strobes in the same cycle. Otherwise the control-register and read-data properties would have to judge mixed accesses. The bench drives every strobe and address at the falling edge, one access per side per cycle, and returns the strobes to zero between accesses. The only deliberate overlap is between the two sides, in the same-cycle collision case of R8. Two instances cover both bit layouts.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    MAP_LEGACY_LO = 2'd0,
    MAP_LEGACY_HI = 2'd1,
    MAP_WIDE      = 2'd2
  } map_e;

  // Bit that carries channel ch in the status and control words.
  function automatic int unsigned flag_pos(map_e m, int nch, int ch);
    if (m == MAP_WIDE) return unsigned'(ch);
    return unsigned'(24 + (nch - 1 - ch));
  endfunction

  function automatic int unsigned tx_addr(map_e m, int ch);
    int unsigned base;
    case (m)
      MAP_LEGACY_LO: base = 'h000;
      MAP_LEGACY_HI: base = 'h020;
      default:       base = 'h200;
    endcase
    return base + 4 * unsigned'(ch);
  endfunction

  function automatic int unsigned rx_addr(map_e m, int ch);
    int unsigned base;
    case (m)
      MAP_LEGACY_LO: base = 'h010;
      MAP_LEGACY_HI: base = 'h040;
      default:       base = 'h280;
    endcase
    return base + 4 * unsigned'(ch);
  endfunction

  function automatic int unsigned stat_addr(map_e m);
    case (m)
      MAP_LEGACY_LO: return 'h020;
      MAP_LEGACY_HI: return 'h060;
      default:       return 'h12C;
    endcase
  endfunction

  function automatic int unsigned ctrl_addr(map_e m);
    case (m)
      MAP_LEGACY_LO: return 'h024;
      MAP_LEGACY_HI: return 'h064;
      default:       return 'h128;
    endcase
  endfunction

endpackage

// File: rtl/mbox_chan.sv
module mbox_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] data,
  output logic              full
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (push) data <= push_data;
      if (push)     full <= 1'b1;
      else if (pop) full <= 1'b0;
    end
  end

  a_r1_push_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> full);
  a_r1_push_latches: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> data == $past(push_data));
  a_r3_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> !full);
  a_r3_pop_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> $stable(data));
  a_r8_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> full);
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> ($stable(data) && $stable(full)));

endmodule

// File: rtl/mbox_a_regs.sv
module mbox_a_regs
  import mbox_pkg::*;
#(
  parameter map_e MAP    = MAP_WIDE,
  parameter int   NCH    = 4,
  parameter int   ADDR_W = 12,
  parameter int   DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       rd,
  input  logic [NCH-1:0]             full,
  input  logic [NCH-1:0][DATA_W-1:0] chan_data,
  output logic [DATA_W-1:0]          rdata,
  output logic [NCH-1:0]             en,
  output logic [NCH-1:0]             pop
);

  localparam logic [ADDR_W-1:0] SR_A = ADDR_W'(stat_addr(MAP));
  localparam logic [ADDR_W-1:0] CR_A = ADDR_W'(ctrl_addr(MAP));

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_mux;
  logic [NCH-1:0]    rx_hit;
  logic              sr_hit;
  logic              cr_hit;
  logic              ctrl_we;

  assign sr_hit  = (addr == SR_A);
  assign cr_hit  = (addr == CR_A);
  assign ctrl_we = wr && cr_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_bits
    localparam int unsigned FP = flag_pos(MAP, NCH, i);
    localparam logic [ADDR_W-1:0] RX_A = ADDR_W'(rx_addr(MAP, i));
    assign en[i]     = ctrl_q[FP];
    assign rx_hit[i] = (addr == RX_A);
    assign pop[i]    = rd && rx_hit[i];
  end

  always_comb begin
    status_w = '0;
    for (int i = 0; i < NCH; i++) status_w[flag_pos(MAP, NCH, i)] = full[i];
  end

  always_comb begin
    rd_mux = '0;
    if (sr_hit) rd_mux = status_w;
    if (cr_hit) rd_mux = ctrl_q;
    for (int i = 0; i < NCH; i++)
      if (rx_hit[i]) rd_mux = chan_data[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      rdata <= rd ? rd_mux : '0;
    end
  end

  a_r4_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_q == $past(wdata));
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
  a_r11_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rdata == '0);
  a_r3_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));

endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter map_e MAP    = MAP_WIDE,
  parameter int   NCH    = 4,
  parameter int   ADDR_W = 12,
  parameter int   DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_rd,
  output logic [DATA_W-1:0] b_rdata,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_rd,
  output logic [DATA_W-1:0] a_rdata,
  output logic              irq
);

  logic [NCH-1:0]             push;
  logic [NCH-1:0]             pop;
  logic [NCH-1:0]             full;
  logic [NCH-1:0]             en;
  logic [NCH-1:0]             pending;
  logic [NCH-1:0][DATA_W-1:0] chan_data;
  logic [NCH-1:0]             tx_hit;
  logic [DATA_W-1:0]          b_mux;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam logic [ADDR_W-1:0] TX_A = ADDR_W'(tx_addr(MAP, i));
    assign tx_hit[i] = (b_addr == TX_A);
    assign push[i]   = b_wr && tx_hit[i];

    mbox_chan #(.DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[i]),
      .push_data (b_wdata),
      .pop       (pop[i]),
      .data      (chan_data[i]),
      .full      (full[i])
    );
  end

  mbox_a_regs #(
    .MAP(MAP), .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_a_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (a_addr),
    .wr        (a_wr),
    .wdata     (a_wdata),
    .rd        (a_rd),
    .full      (full),
    .chan_data (chan_data),
    .rdata     (a_rdata),
    .en        (en),
    .pop       (pop)
  );

  always_comb begin
    b_mux = '0;
    for (int i = 0; i < NCH; i++)
      if (tx_hit[i]) b_mux = chan_data[i];
  end

  assign pending = full & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_rdata <= '0;
      irq     <= 1'b0;
    end else begin
      b_rdata <= b_rd ? b_mux : '0;
      irq     <= |pending;
    end
  end

  a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |=> irq);
  a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |=> !irq);
  a_r1_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push));
  a_r6_mask_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (full[0] && !pop[0]) |=> full[0]);

endmodule

// File: tb/test_mbox_doorbell.sv
module test_mbox_doorbell;
  import mbox_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] b_addr [2];
  logic        b_wr [2];
  logic [31:0] b_wdata [2];
  logic        b_rd [2];
  logic [31:0] b_rdata [2];
  logic [11:0] a_addr [2];
  logic        a_wr [2];
  logic [31:0] a_wdata [2];
  logic        a_rd [2];
  logic [31:0] a_rdata [2];
  logic        irq [2];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_doorbell #(.MAP(MAP_WIDE)) i_mbox_doorbell (
    .clk(clk), .rst_n(rst_n),
    .b_addr(b_addr[0]), .b_wr(b_wr[0]), .b_wdata(b_wdata[0]), .b_rd(b_rd[0]), .b_rdata(b_rdata[0]),
    .a_addr(a_addr[0]), .a_wr(a_wr[0]), .a_wdata(a_wdata[0]), .a_rd(a_rd[0]), .a_rdata(a_rdata[0]),
    .irq(irq[0])
  );

  mbox_doorbell #(.MAP(MAP_LEGACY_LO)) i_mbox_doorbell_leg (
    .clk(clk), .rst_n(rst_n),
    .b_addr(b_addr[1]), .b_wr(b_wr[1]), .b_wdata(b_wdata[1]), .b_rd(b_rd[1]), .b_rdata(b_rdata[1]),
    .a_addr(a_addr[1]), .a_wr(a_wr[1]), .a_wdata(a_wdata[1]), .a_rd(a_rd[1]), .a_rdata(a_rdata[1]),
    .irq(irq[1])
  );

  // Bench-side view of the two maps (u=0 newer, u=1 legacy low).
  function automatic logic [11:0] txa(int u, int ch); return 12'((u == 0 ? 'h200 : 'h000) + 4 * ch); endfunction
  function automatic logic [11:0] rxa(int u, int ch); return 12'((u == 0 ? 'h280 : 'h010) + 4 * ch); endfunction
  function automatic logic [11:0] sra(int u); return u == 0 ? 12'h12C : 12'h020; endfunction
  function automatic logic [11:0] cra(int u); return u == 0 ? 12'h128 : 12'h024; endfunction
  function automatic logic [31:0] fbit(int u, int ch); return u == 0 ? 32'(1) << ch : 32'(1) << (27 - ch); endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(string req, logic [31:0] act, logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic idle_all();
    for (int u = 0; u < 2; u++) begin
      b_addr[u] = '0; b_wr[u] = 0; b_wdata[u] = '0; b_rd[u] = 0;
      a_addr[u] = '0; a_wr[u] = 0; a_wdata[u] = '0; a_rd[u] = 0;
    end
  endtask

  task automatic b_write(int u, logic [11:0] ad, logic [31:0] d);
    @(negedge clk); b_addr[u] = ad; b_wdata[u] = d; b_wr[u] = 1;
    @(negedge clk); b_wr[u] = 0;
  endtask

  task automatic b_read(int u, logic [11:0] ad, output logic [31:0] d);
    @(negedge clk); b_addr[u] = ad; b_rd[u] = 1;
    @(negedge clk); b_rd[u] = 0; d = b_rdata[u];
  endtask

  task automatic a_write(int u, logic [11:0] ad, logic [31:0] d);
    @(negedge clk); a_addr[u] = ad; a_wdata[u] = d; a_wr[u] = 1;
    @(negedge clk); a_wr[u] = 0;
  endtask

  task automatic a_read(int u, logic [11:0] ad, output logic [31:0] d);
    @(negedge clk); a_addr[u] = ad; a_rd[u] = 1;
    @(negedge clk); a_rd[u] = 0; d = a_rdata[u];
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    for (int u = 0; u < 2; u++) begin
      chk_eq("R9 irq after reset", 32'(irq[u]), 0);
      chk_eq("R9 a_rdata after reset", a_rdata[u], 0);
      a_read(u, sra(u), d); chk_eq("R9 status after reset", d, 0);
      a_read(u, cra(u), d); chk_eq("R9 ctrl after reset", d, 0);
      a_read(u, rxa(u, 2), d); chk_eq("R9 rx data after reset", d, 0);
    end
  endtask

  task automatic t_deliver(int u);
    logic [31:0] d;
    b_write(u, txa(u, 2), 32'hA5A5_0002);
    a_read(u, sra(u), d); chk_eq("R1 R2 R12 flag after tx write", d, fbit(u, 2));
    b_read(u, txa(u, 2), d); chk_eq("R11 side-B readback", d, 32'hA5A5_0002);
    a_read(u, rxa(u, 2), d); chk_eq("R3 rx data", d, 32'hA5A5_0002);
    a_read(u, sra(u), d); chk_eq("R3 flag cleared by read", d, 0);
    a_read(u, rxa(u, 2), d); chk_eq("R3 data kept after read", d, 32'hA5A5_0002);
    @(negedge clk); chk_eq("R11 rdata zero without read", a_rdata[u], 0);
  endtask

  task automatic t_all_channels(int u);
    logic [31:0] d;
    logic [31:0] all;
    all = 0;
    for (int ch = 0; ch < 4; ch++) begin
      b_write(u, txa(u, ch), 32'h1000 * (ch + 1) + 32'(u));
      all |= fbit(u, ch);
    end
    a_read(u, sra(u), d); chk_eq("R2 all four flags", d, all);
    a_read(u, rxa(u, 1), d); chk_eq("R3 rx ch1 data", d, 32'h2000 + 32'(u));
    a_read(u, sra(u), d); chk_eq("R3 only ch1 cleared", d, all & ~fbit(u, 1));
    for (int ch = 0; ch < 4; ch++) begin
      a_read(u, rxa(u, ch), d);
      chk_eq("R3 drain data", d, 32'h1000 * (ch + 1) + 32'(u));
    end
    a_read(u, sra(u), d); chk_eq("R3 all drained", d, 0);
  endtask

  task automatic t_irq(int u);
    logic [31:0] d;
    a_write(u, cra(u), 32'hDEAD_BEEF);
    a_read(u, cra(u), d); chk_eq("R4 ctrl full readback", d, 32'hDEAD_BEEF);
    a_write(u, cra(u), fbit(u, 3));
    b_write(u, txa(u, 1), 32'h11);
    @(negedge clk); @(negedge clk);
    chk_eq("R4 enable of other channel gives no irq", 32'(irq[u]), 0);
    a_write(u, cra(u), fbit(u, 0));
    a_read(u, rxa(u, 1), d);
    b_write(u, txa(u, 0), 32'h22);
    chk_eq("R5 irq not yet one clock after flag", 32'(irq[u]), 0);
    @(negedge clk);
    chk_eq("R5 irq one clock after flag", 32'(irq[u]), 1);
    a_write(u, cra(u), 0);
    @(negedge clk);
    chk_eq("R6 irq masked", 32'(irq[u]), 0);
    a_read(u, sra(u), d); chk_eq("R6 flag kept while masked", d, fbit(u, 0));
    a_write(u, cra(u), fbit(u, 0));
    @(negedge clk);
    chk_eq("R6 irq back after re-enable", 32'(irq[u]), 1);
    a_read(u, rxa(u, 0), d); chk_eq("R3 rx ch0 data", d, 32'h22);
    @(negedge clk);
    chk_eq("R5 irq drops after ack", 32'(irq[u]), 0);
    a_write(u, cra(u), 0);
  endtask

  task automatic t_overwrite(int u);
    logic [31:0] d;
    b_write(u, txa(u, 3), 32'h3333_0001);
    b_write(u, txa(u, 3), 32'h3333_0002);
    a_read(u, sra(u), d); chk_eq("R7 flag still set", d, fbit(u, 3));
    a_read(u, rxa(u, 3), d); chk_eq("R7 newer word kept", d, 32'h3333_0002);
    a_read(u, sra(u), d); chk_eq("R7 one read clears", d, 0);
  endtask

  task automatic t_collide(int u);
    logic [31:0] d;
    b_write(u, txa(u, 1), 32'h0000_00AA);
    @(negedge clk);
    b_addr[u] = txa(u, 1); b_wdata[u] = 32'h0000_00BB; b_wr[u] = 1;
    a_addr[u] = rxa(u, 1); a_rd[u] = 1;
    @(negedge clk);
    b_wr[u] = 0; a_rd[u] = 0;
    chk_eq("R8 read returns old word", a_rdata[u], 32'h0000_00AA);
    a_read(u, sra(u), d); chk_eq("R8 flag left set", d, fbit(u, 1));
    a_read(u, rxa(u, 1), d); chk_eq("R8 new word stored", d, 32'h0000_00BB);
  endtask

  task automatic t_ignored(int u);
    logic [31:0] d;
    b_write(u, txa(u, 0), 32'h5555_0000);
    a_read(u, rxa(u, 0), d);
    a_write(u, rxa(u, 0), 32'hFFFF_FFFF);
    a_read(u, rxa(u, 0), d); chk_eq("R10 rx write ignored", d, 32'h5555_0000);
    a_write(u, sra(u), 32'hFFFF_FFFF);
    a_read(u, sra(u), d); chk_eq("R10 status write ignored", d, 0);
    a_write(u, 12'h300, 32'hFFFF_FFFF);
    a_read(u, cra(u), d); chk_eq("R10 unmapped write leaves ctrl", d, 0);
    b_write(u, 12'h300, 32'h1234_5678);
    a_read(u, sra(u), d); chk_eq("R10 unmapped side-B write sets no flag", d, 0);
    a_read(u, 12'h00C + 12'(u) * 12'h100, d); chk_eq("R10 unmapped A read zero", d, 0);
    b_read(u, 12'h300, d); chk_eq("R10 unmapped B read zero", d, 0);
    @(negedge clk);
  endtask

  task automatic t_mid_reset();
    logic [31:0] d;
    for (int u = 0; u < 2; u++) begin
      a_write(u, cra(u), 32'hFFFF_FFFF);
      b_write(u, txa(u, 2), 32'h7777_7777);
    end
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int u = 0; u < 2; u++) begin
      chk_eq("R9 irq cleared by reset", 32'(irq[u]), 0);
      a_read(u, sra(u), d); chk_eq("R9 flags cleared by reset", d, 0);
      a_read(u, cra(u), d); chk_eq("R9 ctrl cleared by reset", d, 0);
      a_read(u, rxa(u, 2), d); chk_eq("R9 data cleared by reset", d, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    for (int u = 0; u < 2; u++) begin
      t_deliver(u);
      t_all_channels(u);
      t_irq(u);
      t_overwrite(u);
      t_collide(u);
      t_ignored(u);
    end
    t_mid_reset();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule